// File: doc/BRIEF.md
# Switch-Driven Byte Memory Loader

This block fills a byte-wide memory by hand from four slide switches. A free-running divider produces a sampling tick once every `TICK_CYCLES` clock cycles. On each tick, if the enable switch is high, the block can do two things. It can add one to the byte under an address pointer. It can also move that pointer one place up or down. Between ticks the switches are ignored, so a switch held for N tick periods produces exactly N actions.

For a display, the block drives out the pointer, the byte at the pointer and the bytes at the three addresses just below it. A second, independent read port lets another agent read any location combinationally. That port has no valid/ready handshake and never applies back-pressure: data follows the address in the same cycle. The read port has no way to stall or reorder the loader. Switch debouncing and display formatting belong to the surrounding logic.

Top module: `switch_loader`

## Requirements
- R1: After reset, the pointer is 0 and every byte of the memory reads 0x00.
- R2: While enable switch `sw_i[0]` is low, ticks change neither the pointer nor any memory byte, whatever the other switches show.
- R3: On a tick with `sw_i[0]`, step switch `sw_i[1]` and direction switch `sw_i[2]` all high, the pointer advances by one, wrapping from 4095 to 0.
- R4: On a tick with `sw_i[0]` and `sw_i[1]` high and `sw_i[2]` low, the pointer moves back by one, wrapping from 0 to 4095.
- R5: On a tick with `sw_i[0]` and increment switch `sw_i[3]` high, the byte at the pointer increases by one modulo 256 (0xFF becomes 0x00).
- R6: When `sw_i[1]` and `sw_i[3]` are both active on one tick, the increment lands on the address the pointer held before that tick, and the pointer moves in the same tick.
- R7: Ticks occur once every `TICK_CYCLES` clock cycles, and each tick performs at most one action set. Switches held steady for N×`TICK_CYCLES` cycles give exactly N actions.
- R8: `cur_byte_o` equals the byte at `ptr_o`. `prev_bytes_o[7:0]`, `[15:8]` and `[23:16]` hold the bytes at `ptr_o-1`, `ptr_o-2` and `ptr_o-3`, each address taken modulo 4096.
- R9: `rd_data_o` equals the byte at `rd_addr_i` in the same cycle and has no effect on the loader's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_i | input | 4 | Switches: [0] enable, [1] step, [2] direction (1 = up), [3] increment |
| rd_addr_i | input | 12 | Address for the auxiliary read port |
| ptr_o | output | 12 | Current address pointer |
| cur_byte_o | output | 8 | Byte stored at the pointer |
| prev_bytes_o | output | 24 | Bytes at pointer-1, -2, -3 in fields [7:0], [15:8], [23:16] |
| rd_data_o | output | 8 | Byte at `rd_addr_i`, combinational |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Pointer wrap at both ends.** A design with a wide or signed pointer would leave the 4096-entry range instead of wrapping.
- **Byte wrap past 0xFF.** A design with a carry-out bug would not show the modulo-256 count after 300 increments.
- **Combined increment-and-move tick.** Applied at every address of a sweep, it exposes a design that writes to the new address instead of the old one.
- **Display window across address 0.** Walking the pointer down through this region exposes window addresses that do not wrap.
- **Ignored switches.** Ticks with enable low, and switches held over several tick periods, expose designs that act when disabled or act more than once per tick.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int SW_EN   = 0;
  localparam int SW_STEP = 1;
  localparam int SW_DIR  = 2;
  localparam int SW_INC  = 3;
  localparam int SW_W    = 4;
  localparam int WIN     = 4;  // pointer byte plus three below
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_CYCLES > 1) begin : g_gap
      // R7
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/byte_mem.sv
module byte_mem #(
  parameter int AW  = 12,
  parameter int DW  = 8,
  parameter int NRD = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata_o[r] = mem_q[raddr_i[r]];
    end
  endgenerate

  // R5
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import loader_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [SW_W-1:0] sw_i,
  input  logic [DW-1:0]   cur_byte_i,
  output logic [AW-1:0]   ptr_o,
  output logic            we_o,
  output logic [DW-1:0]   wdata_o
);
  logic          act;
  logic [AW-1:0] ptr_q;

  assign act     = tick_i & sw_i[SW_EN];
  assign we_o    = act & sw_i[SW_INC];
  assign wdata_o = cur_byte_i + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (act && sw_i[SW_STEP]) begin
      if (sw_i[SW_DIR]) ptr_q <= ptr_q + 1'b1;
      else              ptr_q <= ptr_q - 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_i && sw_i[SW_EN] && sw_i[SW_STEP]) |=> $stable(ptr_q));
  // R3
  ptr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && sw_i[SW_EN] && sw_i[SW_STEP] && sw_i[SW_DIR])
      |=> ptr_q == AW'($past(ptr_q) + 1'b1));
  // R4
  ptr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && sw_i[SW_EN] && sw_i[SW_STEP] && !sw_i[SW_DIR])
      |=> ptr_q == AW'($past(ptr_q) - 1'b1));
endmodule

// File: rtl/switch_loader.sv
module switch_loader
  import loader_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SW_W-1:0]      sw_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [AW-1:0]        ptr_o,
  output logic [DW-1:0]        cur_byte_o,
  output logic [(WIN-1)*DW-1:0] prev_bytes_o,
  output logic [DW-1:0]        rd_data_o
);
  localparam int NRD = WIN + 1;  // window ports plus auxiliary port

  logic                   tick;
  logic                   we;
  logic [DW-1:0]          wdata;
  logic [AW-1:0]          ptr;
  logic [NRD-1:0][AW-1:0] raddr;
  logic [NRD-1:0][DW-1:0] rdata;

  tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  ptr_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sw_i(sw_i),
    .cur_byte_i(rdata[0]), .ptr_o(ptr), .we_o(we), .wdata_o(wdata)
  );

  generate
    for (genvar k = 0; k < WIN; k++) begin : g_win
      assign raddr[k] = ptr - AW'(k);
      if (k > 0) begin : g_prev
        assign prev_bytes_o[(k-1)*DW +: DW] = rdata[k];
      end
    end
  endgenerate
  assign raddr[WIN] = rd_addr_i;

  byte_mem #(.AW(AW), .DW(DW), .NRD(NRD)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  assign ptr_o      = ptr;
  assign cur_byte_o = rdata[0];
  assign rd_data_o  = rdata[WIN];
endmodule

// File: tb/tb_switch_loader.sv
module tb_switch_loader;
  localparam int T     = 8;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sw = 4'h0;
  logic [11:0] rd_addr = '0;
  logic [11:0] ptr;
  logic [7:0]  cur;
  logic [23:0] prev;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  exp_mem [DEPTH];
  logic [11:0] exp_ptr = '0;

  always #2 clk = ~clk;

  switch_loader #(.TICK_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .sw_i(sw), .rd_addr_i(rd_addr),
    .ptr_o(ptr), .cur_byte_o(cur), .prev_bytes_o(prev), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Model of one tick, from the requirements
  task automatic model_tick(input logic [3:0] s);
    if (s[0]) begin
      if (s[3]) exp_mem[exp_ptr] = exp_mem[exp_ptr] + 8'd1;
      if (s[1]) exp_ptr = s[2] ? exp_ptr + 12'd1 : exp_ptr - 12'd1;
    end
  endtask

  // Hold switches for n tick periods: exactly n ticks land (R7)
  task automatic hold(input logic [3:0] s, input int n);
    @(negedge clk);
    sw = s;
    repeat (n * T) @(negedge clk);
    sw = 4'h0;
    for (int i = 0; i < n; i++) model_tick(s);
  endtask

  task automatic check_view(input string tag);
    chk(tag, "ptr", ptr, exp_ptr);
    chk(tag, "cur_byte", cur, exp_mem[exp_ptr]);
    for (int k = 1; k <= 3; k++)
      chk(tag, $sformatf("prev%0d", k), prev[(k-1)*8 +: 8], exp_mem[12'(exp_ptr - 12'(k))]);
  endtask

  task automatic check_rd(input string tag, input int a);
    rd_addr = 12'(a);
    #1;
    chk(tag, $sformatf("rd_data@%0d", a), rd_data, exp_mem[a]);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, pointer 0, memory cleared
    check_view("R1");
    check_rd("R1", 0);
    check_rd("R1", 1234);
    check_rd("R1", 4095);

    // R2: enable low, step and increment ignored
    hold(4'b1110, 3);
    check_view("R2");
    hold(4'b1010, 2);
    check_view("R2");

    // R3 / R7: three ticks up gives pointer 3
    hold(4'b0111, 3);
    check_view("R3_R7");
    chk("R7", "ptr after 3 ticks", ptr, 3);

    // R4: down through 0 wraps to 4095
    hold(4'b0011, 4);
    check_view("R4");
    chk("R4", "wrap down", ptr, 4095);

    // R3: up from 4095 wraps to 0
    hold(4'b0111, 1);
    chk("R3", "wrap up", ptr, 0);

    // R5: 300 increments wrap modulo 256 -> 44
    hold(4'b1001, 300);
    chk("R5", "byte wrap", cur, 44);
    check_view("R5");

    // R6: sweep addresses, each gets (a+1) increments; last one joined with the move up
    for (int a = 0; a < 8; a++) begin
      if (a > 0) hold(4'b1001, a);
      hold(4'b1111, 1);
      chk("R6", $sformatf("ptr after combined tick %0d", a), ptr, a + 1);
    end
    for (int a = 0; a < 8; a++) check_rd("R6", a);

    // R8: walk the pointer down through 0 and check the window at every step
    for (int s = 0; s < 12; s++) begin
      check_view("R8");
      hold(4'b0011, 1);
    end

    // R9: read port sweep, loader idle, view unchanged
    for (int a = 0; a < 16; a++) check_rd("R9", a);
    for (int a = 4090; a < 4096; a++) check_rd("R9", a);
    check_view("R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule